// File: doc/BRIEF.md
# Ping-Pong Output Gamma Table

This block is the last colour stage ahead of a write-out path. It keeps two gamma tables, bank A and bank B. Each bank holds one curve per colour channel, given as `2^IDX_W + 1` points spaced evenly over the input range. Every pixel passes either straight through (bypass) or through the active bank. In the bank, the upper `IDX_W` bits of each channel pick a segment and the lower `CH_W - IDX_W` bits set the position inside it. The output is found by linear interpolation between the segment's two end points.

Software reaches the block through a small register port with four addresses. It always loads the bank that is not active. It sets a colour-select field, writes a start point to the index register, and then streams entries through one data register. A load sequencer (states `LD_IDLE`, `LD_RED`, `LD_GREEN`, `LD_BLUE`, `LD_FULL`) steers each entry to a channel and point. In three-channel order the transitions run `LD_RED -> LD_GREEN -> LD_BLUE -> LD_RED`, and the point advances on leaving `LD_BLUE`. In single-channel order the sequencer stays in its state and advances the point on every write. Any load state moves to `LD_FULL` after the last point. An index write moves any state to the channel's entry state, or to `LD_FULL` if the index is out of range. A colour-select write moves any state to `LD_IDLE`.

Mode and bank writes are held pending and applied only on a frame-start strobe, so a frame never mixes two tables. Reading the control register returns the active mode and bank, which tells software which bank is free for the next load.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset the active mode is bypass, the active bank is A, control readback (address 0) is 0, index readback (address 1) is 0, colour select is 0 and `pix_valid_o` is low.
- R2: The control register (address 0) holds mode in bits 1:0. Only mode 2 maps pixels through a table. Modes 0, 1 and 3 give bypass, where each output channel equals its input channel. Output appears two clock cycles after `pix_valid_i`, with `pix_valid_o` following `pix_valid_i` by two cycles.
- R3: Control bit 4 picks the active bank: 0 is bank A and 1 is bank B.
- R4: A control write changes only pending values. They become active in the cycle after a clock edge at which `frame_start` is high. Control readback returns the active mode in bits 1:0 and the active bank in bit 4.
- R5: Writing the index register (address 1) with a value below `2^IDX_W + 1` sets the load point and arms the sequencer. Data writes (address 2) made while the sequencer is idle change no table entry.
- R6: The colour-select field is address 3, bits 2:0. Value 7, and any value other than 1, 2 or 4, gives three-channel order: red, green, blue per point, with the point advancing after blue. Writing this field disarms the sequencer until the next index write.
- R7: Colour-select 1, 2 or 4 loads only red, only green or only blue, and the point advances on every data write.
- R8: Data writes always go to the bank that is not active. Pixels mapped through the active bank are unaffected by a load in progress.
- R9: After the last point is stored, or after an index write of `2^IDX_W + 1` or more, further data writes are ignored. Index readback then returns `2^IDX_W + 1`, and otherwise returns the next point to be written.
- R10: In table mode each channel outputs `lo + floor((hi - lo) * f / 2^(CH_W-IDX_W))`. Here `lo` and `hi` are the bank entries at the points `s` and `s+1`, `s` is the upper `IDX_W` bits of the input and `f` is the lower bits.
- R11: A table entry is the low `CH_W` bits of the data write; the upper bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 index, 2 data, 3 colour select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Readback of the addressed register (data address reads 0) |
| frame_start | input | 1 | Frame boundary strobe; applies pending mode and bank |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | CH_W | Input red |
| pix_g_i | input | CH_W | Input green |
| pix_b_i | input | CH_W | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | CH_W | Output red |
| pix_g_o | output | CH_W | Output green |
| pix_b_o | output | CH_W | Output blue |

## Verification
The bench builds the block with `CH_W = 8` and `IDX_W = 3`, so each bank has nine points per channel and five fraction bits. A full three-channel load then takes 27 data writes. That size lets the bench fill both banks several times, run random pixels across every segment, including the top segment with an all-ones input, and overrun the last point in each colour order. The short fraction keeps negative slopes and their floor rounding frequent among random entries.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_INDEX = 2'd1;
    localparam logic [1:0] ADDR_DATA  = 2'd2;
    localparam logic [1:0] ADDR_CSEL  = 2'd3;

    // Mode encodings
    localparam logic [1:0] MODE_LUT = 2'd2;

    // Control field positions
    localparam int CTRL_SEL_BIT = 4;

    // Colour-select single-channel codes
    localparam logic [2:0] CSEL_RED   = 3'd1;
    localparam logic [2:0] CSEL_GREEN = 3'd2;
    localparam logic [2:0] CSEL_BLUE  = 3'd4;

    // Channel numbers used on the write port
    localparam logic [1:0] CH_RED   = 2'd0;
    localparam logic [1:0] CH_GREEN = 2'd1;
    localparam logic [1:0] CH_BLUE  = 2'd2;

    typedef enum logic [2:0] {
        LD_IDLE  = 3'd0,
        LD_RED   = 3'd1,
        LD_GREEN = 3'd2,
        LD_BLUE  = 3'd3,
        LD_FULL  = 3'd4
    } ld_state_e;

endpackage

// File: rtl/lut_load_fsm.sv
module lut_load_fsm
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int REG_W = 16,
    localparam int N_PTS = (1 << IDX_W) + 1,
    localparam int PT_W  = $clog2(N_PTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [REG_W-1:0] idx_val,
    input  logic             csel_wr,
    input  logic [2:0]       csel_val,
    input  logic             data_wr,
    output logic             mem_we,
    output logic [1:0]       mem_chan,
    output logic [PT_W-1:0]  ld_idx,
    output logic [2:0]       csel,
    output ld_state_e        ld_state
);

    localparam logic [PT_W-1:0] LAST_PT = PT_W'(N_PTS - 1);

    ld_state_e       state_q, state_d;
    logic [PT_W-1:0] idx_q, idx_d;
    logic [2:0]      csel_q, csel_d;
    logic            single_ch;
    ld_state_e       entry_state;
    logic            at_last;

    // Colour order decode
    always_comb begin
        single_ch = (csel_q == CSEL_RED) || (csel_q == CSEL_GREEN) ||
                    (csel_q == CSEL_BLUE);
        if (csel_q == CSEL_GREEN) begin
            entry_state = LD_GREEN;
        end else if (csel_q == CSEL_BLUE) begin
            entry_state = LD_BLUE;
        end else begin
            entry_state = LD_RED;
        end
        at_last = (idx_q == LAST_PT);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
            csel_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            csel_q  <= csel_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        csel_d  = csel_q;
        if (csel_wr) begin
            csel_d  = csel_val;
            state_d = LD_IDLE;
        end else if (idx_wr) begin
            if (idx_val >= REG_W'(N_PTS)) begin
                state_d = LD_FULL;
                idx_d   = PT_W'(N_PTS);
            end else begin
                state_d = entry_state;
                idx_d   = idx_val[PT_W-1:0];
            end
        end else if (data_wr) begin
            unique case (state_q)
                LD_IDLE, LD_FULL: begin
                    state_d = state_q;
                end
                LD_RED, LD_GREEN: begin
                    if (single_ch) begin
                        idx_d   = idx_q + 1'b1;
                        state_d = at_last ? LD_FULL : state_q;
                    end else begin
                        state_d = (state_q == LD_RED) ? LD_GREEN : LD_BLUE;
                    end
                end
                LD_BLUE: begin
                    idx_d = idx_q + 1'b1;
                    if (at_last) begin
                        state_d = LD_FULL;
                    end else begin
                        state_d = single_ch ? LD_BLUE : LD_RED;
                    end
                end
                default: begin
                    state_d = LD_IDLE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we   = 1'b0;
        mem_chan = CH_RED;
        unique case (state_q)
            LD_RED: begin
                mem_we   = data_wr;
                mem_chan = CH_RED;
            end
            LD_GREEN: begin
                mem_we   = data_wr;
                mem_chan = CH_GREEN;
            end
            LD_BLUE: begin
                mem_we   = data_wr;
                mem_chan = CH_BLUE;
            end
            default: begin
                mem_we   = 1'b0;
                mem_chan = CH_RED;
            end
        endcase
        ld_idx   = idx_q;
        csel     = csel_q;
        ld_state = state_q;
    end

endmodule

// File: rtl/lut_bank_store.sv
module lut_bank_store #(
    parameter int CH_W  = 10,
    parameter int IDX_W = 4,
    localparam int N_PTS = (1 << IDX_W) + 1,
    localparam int PT_W  = $clog2(N_PTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic                       wr_bank,
    input  logic [1:0]                 wr_chan,
    input  logic [PT_W-1:0]            wr_idx,
    input  logic [CH_W-1:0]            wr_data,
    input  logic                       rd_bank,
    input  logic [2:0][IDX_W-1:0]      rd_seg,
    output logic [2:0][CH_W-1:0]       rd_lo,
    output logic [2:0][CH_W-1:0]       rd_hi
);

    logic [CH_W-1:0] lo_b [2][3];
    logic [CH_W-1:0] hi_b [2][3];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar c = 0; c < 3; c++) begin : g_chan
            logic [CH_W-1:0] cell_q [N_PTS];
            logic [IDX_W:0]  seg_lo;
            logic [IDX_W:0]  seg_hi;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int p = 0; p < N_PTS; p++) begin
                        cell_q[p] <= '0;
                    end
                end else if (we && (wr_bank == 1'(b)) && (wr_chan == 2'(c))) begin
                    cell_q[wr_idx] <= wr_data;
                end
            end

            assign seg_lo     = {1'b0, rd_seg[c]};
            assign seg_hi     = seg_lo + 1'b1;
            assign lo_b[b][c] = cell_q[seg_lo];
            assign hi_b[b][c] = cell_q[seg_hi];
        end
    end

    for (genvar c = 0; c < 3; c++) begin : g_rd
        assign rd_lo[c] = rd_bank ? lo_b[1][c] : lo_b[0][c];
        assign rd_hi[c] = rd_bank ? hi_b[1][c] : hi_b[0][c];
    end

endmodule

// File: rtl/lut_interp_pipe.sv
module lut_interp_pipe #(
    parameter int CH_W  = 10,
    parameter int IDX_W = 4,
    localparam int FRAC_W = CH_W - IDX_W,
    localparam int PROD_W = CH_W + FRAC_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_lut,
    input  logic [2:0][CH_W-1:0]  in_pix,
    input  logic [2:0][CH_W-1:0]  in_lo,
    input  logic [2:0][CH_W-1:0]  in_hi,
    output logic                  s1_valid,
    output logic                  s1_lut,
    output logic [2:0][CH_W-1:0]  s1_pix,
    output logic [2:0][CH_W-1:0]  s1_lo,
    output logic [2:0][CH_W-1:0]  s1_hi,
    output logic                  out_valid,
    output logic [2:0][CH_W-1:0]  out_pix
);

    logic [2:0][CH_W-1:0] res;

    // Stage 1: capture pixel and neighbouring entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_lut   <= 1'b0;
            s1_pix   <= '0;
            s1_lo    <= '0;
            s1_hi    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_lut   <= in_lut;
            s1_pix   <= in_pix;
            s1_lo    <= in_lo;
            s1_hi    <= in_hi;
        end
    end

    // Blend per channel
    for (genvar c = 0; c < 3; c++) begin : g_mix
        logic signed [PROD_W-1:0] diff;
        logic signed [PROD_W-1:0] frac;
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] step;
        logic signed [PROD_W-1:0] sum;

        always_comb begin
            diff = PROD_W'($signed({1'b0, s1_hi[c]})) -
                   PROD_W'($signed({1'b0, s1_lo[c]}));
            frac = $signed({{(PROD_W - FRAC_W){1'b0}}, s1_pix[c][FRAC_W-1:0]});
            prod = diff * frac;
            step = prod >>> FRAC_W;
            sum  = PROD_W'($signed({1'b0, s1_lo[c]})) + step;
            res[c] = s1_lut ? sum[CH_W-1:0] : s1_pix[c];
        end
    end

    // Stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_pix   <= res;
        end
    end

endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut
    import gamma_lut_pkg::*;
#(
    parameter int CH_W  = 10,
    parameter int IDX_W = 4,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             frame_start,
    input  logic             pix_valid_i,
    input  logic [CH_W-1:0]  pix_r_i,
    input  logic [CH_W-1:0]  pix_g_i,
    input  logic [CH_W-1:0]  pix_b_i,
    output logic             pix_valid_o,
    output logic [CH_W-1:0]  pix_r_o,
    output logic [CH_W-1:0]  pix_g_o,
    output logic [CH_W-1:0]  pix_b_o
);

    localparam int N_PTS  = (1 << IDX_W) + 1;
    localparam int PT_W   = $clog2(N_PTS + 1);
    localparam int FRAC_W = CH_W - IDX_W;

    // Control registers: pending and active copies
    logic [1:0] pend_mode, act_mode;
    logic       pend_sel,  act_sel;
    logic       lut_on;

    logic            ctrl_wr, idx_wr, data_wr, csel_wr;
    logic            mem_we;
    logic [1:0]      mem_chan;
    logic [PT_W-1:0] ld_idx;
    logic [2:0]      csel;
    ld_state_e       ld_state;
    logic            wr_bank;

    logic [2:0][CH_W-1:0]  pix_in;
    logic [2:0][IDX_W-1:0] seg;
    logic [2:0][CH_W-1:0]  rd_lo, rd_hi;
    logic                  s1_valid, s1_lut;
    logic [2:0][CH_W-1:0]  s1_pix, s1_lo, s1_hi;
    logic [2:0][CH_W-1:0]  out_pix;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign idx_wr  = reg_wr && (reg_addr == ADDR_INDEX);
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
    assign csel_wr = reg_wr && (reg_addr == ADDR_CSEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mode <= '0;
            pend_sel  <= 1'b0;
            act_mode  <= '0;
            act_sel   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                pend_mode <= reg_wdata[1:0];
                pend_sel  <= reg_wdata[CTRL_SEL_BIT];
            end
            if (frame_start) begin
                act_mode <= pend_mode;
                act_sel  <= pend_sel;
            end
        end
    end

    assign lut_on  = (act_mode == MODE_LUT);
    assign wr_bank = ~act_sel;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[1:0]          = act_mode;
                reg_rdata[CTRL_SEL_BIT] = act_sel;
            end
            ADDR_INDEX: reg_rdata[PT_W-1:0] = ld_idx;
            ADDR_CSEL:  reg_rdata[2:0]      = csel;
            default:    reg_rdata           = '0;
        endcase
    end

    lut_load_fsm #(
        .IDX_W (IDX_W),
        .REG_W (REG_W)
    ) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .idx_val  (reg_wdata),
        .csel_wr  (csel_wr),
        .csel_val (reg_wdata[2:0]),
        .data_wr  (data_wr),
        .mem_we   (mem_we),
        .mem_chan (mem_chan),
        .ld_idx   (ld_idx),
        .csel     (csel),
        .ld_state (ld_state)
    );

    assign pix_in[0] = pix_r_i;
    assign pix_in[1] = pix_g_i;
    assign pix_in[2] = pix_b_i;

    for (genvar c = 0; c < 3; c++) begin : g_seg
        assign seg[c] = pix_in[c][CH_W-1 -: IDX_W];
    end

    lut_bank_store #(
        .CH_W  (CH_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .wr_bank (wr_bank),
        .wr_chan (mem_chan),
        .wr_idx  (ld_idx),
        .wr_data (reg_wdata[CH_W-1:0]),
        .rd_bank (act_sel),
        .rd_seg  (seg),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    lut_interp_pipe #(
        .CH_W  (CH_W),
        .IDX_W (IDX_W)
    ) u_interp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid_i),
        .in_lut    (lut_on),
        .in_pix    (pix_in),
        .in_lo     (rd_lo),
        .in_hi     (rd_hi),
        .s1_valid  (s1_valid),
        .s1_lut    (s1_lut),
        .s1_pix    (s1_pix),
        .s1_lo     (s1_lo),
        .s1_hi     (s1_hi),
        .out_valid (pix_valid_o),
        .out_pix   (out_pix)
    );

    assign pix_r_o = out_pix[0];
    assign pix_g_o = out_pix[1];
    assign pix_b_o = out_pix[2];

endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker
    import gamma_lut_pkg::*;
#(
    parameter int CH_W  = 10,
    parameter int IDX_W = 4,
    localparam int N_PTS = (1 << IDX_W) + 1,
    localparam int PT_W  = $clog2(N_PTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic [1:0]           act_mode,
    input logic                 act_sel,
    input logic                 mem_we,
    input logic                 wr_bank,
    input ld_state_e            ld_state,
    input logic [PT_W-1:0]      ld_idx,
    input logic                 pix_valid_i,
    input logic                 s1_valid,
    input logic                 s1_lut,
    input logic [2:0][CH_W-1:0] s1_pix,
    input logic [2:0][CH_W-1:0] s1_lo,
    input logic [2:0][CH_W-1:0] s1_hi,
    input logic                 pix_valid_o,
    input logic [CH_W-1:0]      pix_r_o
);

    a_r4_switch_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> ($stable(act_mode) && $stable(act_sel)));

    a_r8_load_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_bank != act_sel));

    a_r5_idle_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_state == LD_IDLE) || (ld_state == LD_FULL)) |-> !mem_we);

    a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ld_idx <= PT_W'(N_PTS));

    a_r9_full_index: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_FULL) |-> (ld_idx == PT_W'(N_PTS)));

    a_r2_stage1_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> s1_valid);

    a_r2_stage2_valid: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> pix_valid_o);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !pix_valid_o);

    a_r2_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_lut) |=> (pix_r_o == $past(s1_pix[0])));

    a_r10_between_points: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_lut) |=>
            ((pix_r_o >= (($past(s1_lo[0]) < $past(s1_hi[0])) ? $past(s1_lo[0]) : $past(s1_hi[0]))) &&
             (pix_r_o <= (($past(s1_lo[0]) < $past(s1_hi[0])) ? $past(s1_hi[0]) : $past(s1_lo[0])))));

endmodule

bind gamma_pingpong_lut gamma_lut_checker #(
    .CH_W  (CH_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .act_mode    (act_mode),
    .act_sel     (act_sel),
    .mem_we      (mem_we),
    .wr_bank     (wr_bank),
    .ld_state    (ld_state),
    .ld_idx      (ld_idx),
    .pix_valid_i (pix_valid_i),
    .s1_valid    (s1_valid),
    .s1_lut      (s1_lut),
    .s1_pix      (s1_pix),
    .s1_lo       (s1_lo),
    .s1_hi       (s1_hi),
    .pix_valid_o (pix_valid_o),
    .pix_r_o     (pix_r_o)
);

// File: tb/gamma_pingpong_lut_bench.sv
`timescale 1ns/1ps
module gamma_pingpong_lut_bench;

    localparam int CH_W   = 8;
    localparam int IDX_W  = 3;
    localparam int REG_W  = 16;
    localparam int N_PTS  = (1 << IDX_W) + 1;
    localparam int FRAC_W = CH_W - IDX_W;
    localparam int CMASK  = (1 << CH_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             reg_wr;
    logic [1:0]       reg_addr;
    logic [REG_W-1:0] reg_wdata;
    logic [REG_W-1:0] reg_rdata;
    logic             frame_start;
    logic             pix_valid_i;
    logic [CH_W-1:0]  pix_r_i, pix_g_i, pix_b_i;
    logic             pix_valid_o;
    logic [CH_W-1:0]  pix_r_o, pix_g_o, pix_b_o;

    always #2 clk = ~clk;

    gamma_pingpong_lut #(
        .CH_W  (CH_W),
        .IDX_W (IDX_W),
        .REG_W (REG_W)
    ) u_gamma_pingpong_lut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .frame_start (frame_start),
        .pix_valid_i (pix_valid_i),
        .pix_r_i     (pix_r_i),
        .pix_g_i     (pix_g_i),
        .pix_b_i     (pix_b_i),
        .pix_valid_o (pix_valid_o),
        .pix_r_o     (pix_r_o),
        .pix_g_o     (pix_g_o),
        .pix_b_o     (pix_b_o)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // Requirement-level model
    int m_bank [2][3][N_PTS];
    int m_pmode = 0, m_psel = 0, m_amode = 0, m_asel = 0;
    int m_csel = 0, m_st = 0, m_idx = 0;   // m_st: 0 idle, 1 red, 2 green, 3 blue, 4 full

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_ch(input int v, input int ch);
        int seg, fr, lo, hi;
        if (m_amode != 2) return v;
        seg = v >> FRAC_W;
        fr  = v & ((1 << FRAC_W) - 1);
        lo  = m_bank[m_asel][ch][seg];
        hi  = m_bank[m_asel][ch][seg + 1];
        return lo + (((hi - lo) * fr) >>> FRAC_W);
    endfunction

    function automatic bit single_order();
        return (m_csel == 1) || (m_csel == 2) || (m_csel == 4);
    endfunction

    task automatic wreg(input int addr, input int data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 2'(addr);
        reg_wdata = REG_W'(data);
        @(negedge clk);
        reg_wr    = 1'b0;
        case (addr)
            0: begin m_pmode = data & 3; m_psel = (data >> 4) & 1; end
            1: begin
                if (data >= N_PTS) begin m_st = 4; m_idx = N_PTS; end
                else begin
                    m_idx = data;
                    m_st  = (m_csel == 2) ? 2 : (m_csel == 4) ? 3 : 1;
                end
            end
            2: begin
                if (m_st >= 1 && m_st <= 3) begin
                    m_bank[1 - m_asel][m_st - 1][m_idx] = data & CMASK;
                    if (single_order()) begin
                        m_idx++;
                        if (m_idx == N_PTS) m_st = 4;
                    end else if (m_st == 3) begin
                        m_idx++;
                        m_st = (m_idx == N_PTS) ? 4 : 1;
                    end else begin
                        m_st++;
                    end
                end
            end
            default: begin m_csel = data & 7; m_st = 0; end
        endcase
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_amode = m_pmode;
        m_asel  = m_psel;
    endtask

    task automatic rd(input int addr, input int exp, input string req);
        @(negedge clk);
        reg_addr = 2'(addr);
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic pix(input int r, input int g, input int b, input string req);
        int er, eg, eb;
        er = expect_ch(r, 0);
        eg = expect_ch(g, 1);
        eb = expect_ch(b, 2);
        @(negedge clk);
        pix_valid_i = 1'b1;
        pix_r_i = CH_W'(r); pix_g_i = CH_W'(g); pix_b_i = CH_W'(b);
        @(negedge clk);
        pix_valid_i = 1'b0;
        @(negedge clk);
        check({req, " valid"}, int'(pix_valid_o), 1);
        check({req, " red"},   int'(pix_r_o), er);
        check({req, " green"}, int'(pix_g_o), eg);
        check({req, " blue"},  int'(pix_b_o), eb);
    endtask

    task automatic rand_pix(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            pix(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256), req);
        end
    endtask

    task automatic full_load3(input string req);
        wreg(3, 7);
        wreg(1, 0);
        for (int i = 0; i < 3 * N_PTS; i++) wreg(2, int'($urandom & 16'hFFFF));
        rd(1, N_PTS, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        frame_start = 1'b0; pix_valid_i = 1'b0;
        pix_r_i = '0; pix_g_i = '0; pix_b_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 valid_o", int'(pix_valid_o), 0);
        rd(0, 0, "R1 ctrl");
        rd(1, 0, "R1 index");
        rd(3, 0, "R1 csel");

        // R2 bypass
        rand_pix(20, "R2 bypass mode0");
        pix(0, 255, 128, "R2 bypass corners");

        // R5 data writes while idle are ignored: bank B stays zero
        for (int i = 0; i < 4; i++) wreg(2, 200 + i);
        wreg(0, 16'h12);
        rd(0, 0, "R4 pending not active");
        pix(40, 80, 120, "R4 still bypass before frame");
        frame();
        rd(0, 16'h12, "R4 active readback");
        pix(100, 200, 37, "R5 idle writes ignored");

        // Back to bank A table mode, then load B fully (R6, R11)
        wreg(0, 16'h02);
        frame();
        rd(0, 2, "R3 bank A active");
        full_load3("R9 index after full load");
        wreg(2, 77);
        rd(1, N_PTS, "R9 index stays after overrun");
        wreg(0, 16'h12);
        frame();
        rand_pix(40, "R10 bank B interp R6 R11");
        pix(255, 255, 255, "R10 top segment");
        pix(0, 0, 0, "R10 zero input");

        // R7 single-channel loads into bank A while B is mapped (R8)
        wreg(3, 1); wreg(1, 0);
        for (int i = 0; i < N_PTS; i++) begin
            wreg(2, int'($urandom & 16'hFFFF));
            pix(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256), "R8 active unaffected");
        end
        rd(1, N_PTS, "R7 red load reaches end");
        wreg(3, 2); wreg(1, 3);
        for (int i = 0; i < 3; i++) wreg(2, int'($urandom & 16'hFFFF));
        rd(1, 6, "R7 green point advance");
        wreg(3, 4); wreg(1, N_PTS - 2);
        for (int i = 0; i < 4; i++) wreg(2, int'($urandom & 16'hFFFF));
        rd(1, N_PTS, "R9 blue overrun");
        rd(3, 4, "R6 csel readback");
        wreg(0, 16'h02);
        frame();
        rd(0, 2, "R3 select A readback");
        rand_pix(30, "R7 R3 bank A interp");

        // R6 unusual colour select behaves as three-channel
        wreg(3, 5); wreg(1, 2);
        for (int i = 0; i < 5; i++) wreg(2, int'($urandom & 16'hFFFF));
        rd(1, 3, "R6 csel 5 acts as rgb");
        wreg(3, 7);
        rd(1, 3, "R6 csel write keeps index");
        for (int i = 0; i < 3; i++) wreg(2, 11);
        wreg(1, 40);
        rd(1, N_PTS, "R9 out of range index");

        // Reserved modes bypass (R2)
        wreg(0, 16'h13);
        frame();
        rand_pix(8, "R2 mode3 bypass");
        wreg(0, 16'h11);
        frame();
        rand_pix(8, "R2 mode1 bypass");
        wreg(0, 16'h12);
        frame();
        rand_pix(20, "R10 R8 bank B after loads");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule